// File: doc/BRIEF.md
# Transmit Fault Classifier and Gate Inhibitor

This block sits between the reply scheduler and the transmit chain. It receives fault and warning flags from the power-amplifier and frequency-synthesis monitors and sorts them into three classes. A protect-class fault (over-temperature, over-current, severe mismatch) forces the transmit gate off within the same cycle. The inhibit then stays latched until an explicit clear. A degrade-class warning (unstable lock, shrinking thermal margin, an interference episode) leaves transmission on but caps how many gate-active cycles fit in a fixed window. A maintenance-class trend flag is only reported. The block also takes the scheduler's gate request and truncates any pulse that runs longer than a programmable maximum width.

Every protect trigger and every truncated pulse writes one log record. The record holds a cycle time tag, a reason code and a snapshot of three sensor readings. Degrade episodes carry their own counters for entries, time spent in the class and recoveries. Dropped duty-limited cycles, protect triggers and width faults are counted as well. The status outputs give the highest active class and a sticky bit for each class.

Top module: `txguard_top`

## Requirements
- R1: While any of `ovt_flag`, `ovc_flag` or `vswr_flag` is high, `gate_out` is low in that same cycle and `status_class` reads 3 (protect).
- R2: Once any protect flag has been high, the protect class stays in force until a cycle in which `clr_protect` is high and all three protect flags are low. Gating stays off until the cycle after that one. A clear while a protect flag is high has no effect.
- R3: `gate_out` is high only when `gate_req` and `lock_ok` are both high, and no other rule blocks the cycle.
- R4: The free-running time tag is 0 in the first cycle after reset and counts up by one per cycle. In a cycle where the OR of the protect flags rises, one cycle later `log_valid` pulses with that cycle's time tag and the snapshot inputs of that cycle. The reason code is 1 for over-temperature, 2 for over-current and 3 for mismatch, in that priority order. `prot_events` increments at the same time.
- R5: While any degrade flag is high, at most DUTY_MAX gate-active cycles are let through in each window of DUTY_WIN cycles. Windows start when the time tag is a multiple of DUTY_WIN, and every gate-active cycle of the window counts, including those before degrade began. A request blocked only by this limit increments `duty_drops`.
- R6: `deg_episodes` increments one cycle after the OR of the degrade flags rises. `deg_cycles` increments one cycle after each cycle in which it is high. `deg_recoveries` increments one cycle after it falls.
- R7: `trend_warn` sets `status_class` to 1 when no higher class is active and never changes `gate_out`.
- R8: In an unbroken run of `gate_req`, only the first `max_width` cycles may pass; a value of 0 blocks all of them. On the first cut cycle, `width_faults` increments and a record with reason 4 is logged, unless a protect record is written in that same cycle.
- R9: `status_class` is 3, 2, 1 or 0 for protect, degrade, maintenance or none, with the highest class winning. `status_sticky` bits 2, 1 and 0 are set one cycle after their class is active. `clr_protect` clears them unless the class is still active. All status, log and counter outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovt_flag | input | 1 | Amplifier over-temperature (protect) |
| ovc_flag | input | 1 | Amplifier over-current (protect) |
| vswr_flag | input | 1 | Severe output mismatch (protect) |
| lock_unstable | input | 1 | Repeated synthesizer lock loss (degrade) |
| thermal_warn | input | 1 | Thermal margin shrinking (degrade) |
| intf_warn | input | 1 | Interference episode in progress (degrade) |
| trend_warn | input | 1 | Slow trend flag (maintenance) |
| lock_ok | input | 1 | Lock and reference healthy |
| clr_protect | input | 1 | Clear request for the protect latch and sticky bits |
| gate_req | input | 1 | Gate request from the scheduler |
| max_width | input | WW | Longest allowed gate run, in cycles |
| snap_temp | input | SW | Temperature reading for the snapshot |
| snap_curr | input | SW | Current reading for the snapshot |
| snap_refl | input | SW | Reflected-power reading for the snapshot |
| gate_out | output | 1 | Transmit gate |
| status_class | output | 2 | Highest active class |
| status_sticky | output | 3 | Sticky class bits {protect, degrade, maintenance} |
| log_valid | output | 1 | One-cycle pulse marking a new log record |
| log_time | output | TW | Time tag of the record |
| log_reason | output | 3 | Reason code of the record |
| log_temp | output | SW | Temperature snapshot |
| log_curr | output | SW | Current snapshot |
| log_refl | output | SW | Reflected-power snapshot |
| prot_events | output | CW | Protect trigger count |
| deg_episodes | output | CW | Degrade entries |
| deg_cycles | output | CW | Cycles spent in degrade |
| deg_recoveries | output | CW | Degrade exits |
| duty_drops | output | CW | Requests dropped by the duty limit |
| width_faults | output | CW | Truncated gate runs |

## Verification
The assertions check several rules on every cycle: the protect flags force the gate off and select class 3, the protect class holds until a clear, the gate stays off without lock, the sticky protect bit follows the class, and a rising protect flag produces a log record with a protect reason. Independent counters in the checker also bound the gate-active cycles in each degrade window and the length of each gate run. Only the bench scenarios can show the exact values. These are the reason-code priority, the time tags and snapshots, the counter totals, the point where a run is cut for each width from 0 to 5, and the fact that a trend flag or a clear during an active fault changes nothing. The bench shows them by comparing every output, every cycle, against a model built from the requirements.

// File: rtl/txg_pkg.sv
package txg_pkg;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_MAINT   = 2'd1,
    CLS_DEGRADE = 2'd2,
    CLS_PROTECT = 2'd3
  } tx_class_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_OVERTEMP = 3'd1,
    RSN_OVERCUR  = 3'd2,
    RSN_MISMATCH = 3'd3,
    RSN_WIDTH    = 3'd4
  } reason_e;

  // Highest active class wins.
  function automatic tx_class_e pick_class(input logic prot, input logic deg, input logic maint);
    if (prot)       return CLS_PROTECT;
    else if (deg)   return CLS_DEGRADE;
    else if (maint) return CLS_MAINT;
    else            return CLS_NONE;
  endfunction

  // Protect reason priority: temperature, then current, then mismatch.
  function automatic reason_e protect_reason(input logic ot, input logic oc);
    if (ot)      return RSN_OVERTEMP;
    else if (oc) return RSN_OVERCUR;
    else         return RSN_MISMATCH;
  endfunction

endpackage

// File: rtl/txg_classify.sv
module txg_classify
  import txg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovt,
  input  logic          ovc,
  input  logic          vswr,
  input  logic          w_lock,
  input  logic          w_therm,
  input  logic          w_intf,
  input  logic          trend,
  input  logic          clr,
  output logic          prot_any,
  output logic          prot_hold,
  output logic          prot_rise,
  output logic          deg_any,
  output logic [1:0]    cls,
  output logic [2:0]    sticky,
  output logic [CW-1:0] episodes,
  output logic [CW-1:0] dwell,
  output logic [CW-1:0] recoveries
);
  logic latch_q, prot_q, deg_q;
  logic deg_rise, deg_fall;

  assign prot_any  = ovt | ovc | vswr;
  assign deg_any   = w_lock | w_therm | w_intf;
  assign prot_hold = prot_any | latch_q;
  assign prot_rise = prot_any & ~prot_q;
  assign deg_rise  = deg_any & ~deg_q;
  assign deg_fall  = ~deg_any & deg_q;
  assign cls       = pick_class(prot_hold, deg_any, trend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= 1'b0;
      prot_q     <= 1'b0;
      deg_q      <= 1'b0;
      sticky     <= '0;
      episodes   <= '0;
      dwell      <= '0;
      recoveries <= '0;
    end else begin
      latch_q <= prot_any | (latch_q & ~clr);
      prot_q  <= prot_any;
      deg_q   <= deg_any;
      sticky  <= (clr ? 3'b000 : sticky) | {prot_hold, deg_any, trend};
      if (deg_rise) episodes   <= episodes + 1'b1;
      if (deg_any)  dwell      <= dwell + 1'b1;
      if (deg_fall) recoveries <= recoveries + 1'b1;
    end
  end
endmodule

// File: rtl/txg_width.sv
module txg_width #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [WW-1:0] max_width,
  output logic          width_ok,
  output logic          trunc_evt
);
  logic [WW-1:0] run_len;
  logic          cut_seen;
  logic          at_limit;

  assign at_limit  = run_len >= max_width;
  assign width_ok  = ~at_limit;
  assign trunc_evt = req & at_limit & ~cut_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= '0;
      cut_seen <= 1'b0;
    end else if (req) begin
      if (!at_limit) run_len <= run_len + 1'b1;
      cut_seen <= cut_seen | trunc_evt;
    end else begin
      run_len  <= '0;
      cut_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/txg_duty.sv
module txg_duty #(
  parameter int WIN   = 16,
  parameter int MAXON = 4,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          limit_en,
  input  logic          pass_in,
  output logic          gate,
  output logic          win_last,
  output logic [CW-1:0] drops
);
  localparam int WINW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int UW   = $clog2(MAXON + 1);

  logic [WINW-1:0] win_cnt;
  logic [UW-1:0]   used;
  logic            duty_ok;

  assign win_last = win_cnt == WINW'(WIN - 1);
  assign duty_ok  = ~limit_en | (used < UW'(MAXON));
  assign gate     = pass_in & duty_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      used    <= '0;
      drops   <= '0;
    end else begin
      win_cnt <= win_last ? '0 : win_cnt + 1'b1;
      if (win_last)                        used <= '0;
      else if (gate && used != UW'(MAXON)) used <= used + 1'b1;
      if (pass_in && !duty_ok) drops <= drops + 1'b1;
    end
  end
endmodule

// File: rtl/txguard_top.sv
module txguard_top
  import txg_pkg::*;
#(
  parameter int WW        = 8,
  parameter int SW        = 10,
  parameter int TW        = 16,
  parameter int CW        = 16,
  parameter int DUTY_WIN  = 16,
  parameter int DUTY_MAX  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovt_flag,
  input  logic          ovc_flag,
  input  logic          vswr_flag,
  input  logic          lock_unstable,
  input  logic          thermal_warn,
  input  logic          intf_warn,
  input  logic          trend_warn,
  input  logic          lock_ok,
  input  logic          clr_protect,
  input  logic          gate_req,
  input  logic [WW-1:0] max_width,
  input  logic [SW-1:0] snap_temp,
  input  logic [SW-1:0] snap_curr,
  input  logic [SW-1:0] snap_refl,
  output logic          gate_out,
  output logic [1:0]    status_class,
  output logic [2:0]    status_sticky,
  output logic          log_valid,
  output logic [TW-1:0] log_time,
  output logic [2:0]    log_reason,
  output logic [SW-1:0] log_temp,
  output logic [SW-1:0] log_curr,
  output logic [SW-1:0] log_refl,
  output logic [CW-1:0] prot_events,
  output logic [CW-1:0] deg_episodes,
  output logic [CW-1:0] deg_cycles,
  output logic [CW-1:0] deg_recoveries,
  output logic [CW-1:0] duty_drops,
  output logic [CW-1:0] width_faults
);
  logic          prot_any, prot_hold, prot_rise, deg_any;
  logic          width_ok, trunc_evt, win_last, pass_in;
  logic [TW-1:0] tick;

  txg_classify #(.CW(CW)) u_cls (
    .clk(clk), .rst_n(rst_n),
    .ovt(ovt_flag), .ovc(ovc_flag), .vswr(vswr_flag),
    .w_lock(lock_unstable), .w_therm(thermal_warn), .w_intf(intf_warn),
    .trend(trend_warn), .clr(clr_protect),
    .prot_any(prot_any), .prot_hold(prot_hold), .prot_rise(prot_rise),
    .deg_any(deg_any), .cls(status_class), .sticky(status_sticky),
    .episodes(deg_episodes), .dwell(deg_cycles), .recoveries(deg_recoveries)
  );

  txg_width #(.WW(WW)) u_wid (
    .clk(clk), .rst_n(rst_n), .req(gate_req), .max_width(max_width),
    .width_ok(width_ok), .trunc_evt(trunc_evt)
  );

  // Request survives width, lock and protect checks; duty limit comes last.
  assign pass_in = gate_req & width_ok & lock_ok & ~prot_hold;

  txg_duty #(.WIN(DUTY_WIN), .MAXON(DUTY_MAX), .CW(CW)) u_duty (
    .clk(clk), .rst_n(rst_n), .limit_en(deg_any), .pass_in(pass_in),
    .gate(gate_out), .win_last(win_last), .drops(duty_drops)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick         <= '0;
      log_valid    <= 1'b0;
      log_time     <= '0;
      log_reason   <= RSN_NONE;
      log_temp     <= '0;
      log_curr     <= '0;
      log_refl     <= '0;
      prot_events  <= '0;
      width_faults <= '0;
    end else begin
      tick      <= tick + 1'b1;
      log_valid <= prot_rise | trunc_evt;
      if (prot_rise || trunc_evt) begin
        log_time   <= tick;
        log_reason <= prot_rise ? protect_reason(ovt_flag, ovc_flag) : RSN_WIDTH;
        log_temp   <= snap_temp;
        log_curr   <= snap_curr;
        log_refl   <= snap_refl;
      end
      if (prot_rise) prot_events  <= prot_events + 1'b1;
      if (trunc_evt) width_faults <= width_faults + 1'b1;
    end
  end
endmodule

// File: rtl/txg_checker.sv
module txg_checker #(
  parameter int WW    = 8,
  parameter int WIN   = 16,
  parameter int MAXON = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ovt_flag,
  input logic          ovc_flag,
  input logic          vswr_flag,
  input logic          lock_ok,
  input logic          clr_protect,
  input logic [WW-1:0] max_width,
  input logic          gate_out,
  input logic [1:0]    status_class,
  input logic [2:0]    status_sticky,
  input logic          log_valid,
  input logic [2:0]    log_reason,
  input logic          deg_any,
  input logic          win_last
);
  localparam int DW = $clog2(WIN + 1);

  logic [DW-1:0] win_gates;
  logic [WW:0]   run_gates;
  logic          pflag;

  assign pflag = ovt_flag | ovc_flag | vswr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_gates <= '0;
      run_gates <= '0;
    end else begin
      if (win_last)      win_gates <= '0;
      else if (gate_out) win_gates <= win_gates + 1'b1;
      if (!gate_out)                 run_gates <= '0;
      else if (run_gates != '1)      run_gates <= run_gates + 1'b1;
    end
  end

  a_r1_protect_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    pflag |-> (!gate_out && status_class == 2'd3));

  a_r2_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status_class == 2'd3 && !clr_protect) |=> status_class == 2'd3);

  a_r3_lock_required: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ok |-> !gate_out);

  a_r4_protect_logged: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pflag) |=> (log_valid && log_reason >= 3'd1 && log_reason <= 3'd3));

  a_r5_duty_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (deg_any && gate_out) |-> win_gates < DW'(MAXON));

  a_r8_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    gate_out |-> run_gates < {1'b0, max_width});

  a_r9_sticky_protect: assert property (@(posedge clk) disable iff (!rst_n)
    status_class == 2'd3 |=> status_sticky[2]);

endmodule

bind txguard_top txg_checker #(.WW(WW), .WIN(DUTY_WIN), .MAXON(DUTY_MAX)) u_txg_chk (
  .clk(clk), .rst_n(rst_n),
  .ovt_flag(ovt_flag), .ovc_flag(ovc_flag), .vswr_flag(vswr_flag),
  .lock_ok(lock_ok), .clr_protect(clr_protect), .max_width(max_width),
  .gate_out(gate_out), .status_class(status_class), .status_sticky(status_sticky),
  .log_valid(log_valid), .log_reason(log_reason),
  .deg_any(deg_any), .win_last(win_last)
);

// File: tb/test_txguard_top.sv
module test_txguard_top;
  localparam int WW = 8, SW = 10, TW = 16, CW = 16, WIN = 16, M = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ovt_flag = 0, ovc_flag = 0, vswr_flag = 0, lock_unstable = 0, thermal_warn = 0;
  logic intf_warn = 0, trend_warn = 0, lock_ok = 0, clr_protect = 0, gate_req = 0;
  logic [WW-1:0] max_width = '0;
  logic [SW-1:0] snap_temp = '0, snap_curr = '0, snap_refl = '0;
  logic gate_out, log_valid;
  logic [1:0] status_class;
  logic [2:0] status_sticky, log_reason;
  logic [TW-1:0] log_time;
  logic [SW-1:0] log_temp, log_curr, log_refl;
  logic [CW-1:0] prot_events, deg_episodes, deg_cycles, deg_recoveries, duty_drops, width_faults;

  always #5 clk = ~clk;

  txguard_top #(.WW(WW), .SW(SW), .TW(TW), .CW(CW), .DUTY_WIN(WIN), .DUTY_MAX(M)) i_txguard_top (
    .clk(clk), .rst_n(rst_n), .ovt_flag(ovt_flag), .ovc_flag(ovc_flag), .vswr_flag(vswr_flag),
    .lock_unstable(lock_unstable), .thermal_warn(thermal_warn), .intf_warn(intf_warn),
    .trend_warn(trend_warn), .lock_ok(lock_ok), .clr_protect(clr_protect), .gate_req(gate_req),
    .max_width(max_width), .snap_temp(snap_temp), .snap_curr(snap_curr), .snap_refl(snap_refl),
    .gate_out(gate_out), .status_class(status_class), .status_sticky(status_sticky),
    .log_valid(log_valid), .log_time(log_time), .log_reason(log_reason), .log_temp(log_temp),
    .log_curr(log_curr), .log_refl(log_refl), .prot_events(prot_events),
    .deg_episodes(deg_episodes), .deg_cycles(deg_cycles), .deg_recoveries(deg_recoveries),
    .duty_drops(duty_drops), .width_faults(width_faults)
  );

  // Stimulus shadows, applied at the falling edge.
  int s_ot = 0, s_oc = 0, s_mm = 0, s_wl = 0, s_wt = 0, s_wi = 0, s_tr = 0;
  int s_lock = 1, s_clr = 0, s_req = 0, s_mw = 8;

  // Reference state built from the requirements.
  int t = 0, plat = 0, pq = 0, dq = 0, rlen = 0, tseen = 0, used = 0, sticky = 0;
  int pe = 0, wf = 0, ep = 0, dcy = 0, rc = 0, drops = 0;
  int lv = 0, ltime = 0, lrsn = 0, ltemp = 0, lcurr = 0, lrefl = 0;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s at t=%0d act=%0d exp=%0d", tag, nm, t, act, exp);
    end
  endtask

  task automatic step();
    int pany, dany, pcls, ecls, wok, dok, pass, egate, pevt, tevt, tp, cu, rf;
    tp = (t * 7 + 3) % 1024; cu = (t * 13 + 5) % 1024; rf = (t * 29 + 11) % 1024;
    ovt_flag = s_ot[0]; ovc_flag = s_oc[0]; vswr_flag = s_mm[0];
    lock_unstable = s_wl[0]; thermal_warn = s_wt[0]; intf_warn = s_wi[0];
    trend_warn = s_tr[0]; lock_ok = s_lock[0]; clr_protect = s_clr[0];
    gate_req = s_req[0]; max_width = WW'(s_mw);
    snap_temp = SW'(tp); snap_curr = SW'(cu); snap_refl = SW'(rf);
    #1;
    pany = s_ot | s_oc | s_mm;
    dany = s_wl | s_wt | s_wi;
    pcls = pany | plat;
    ecls = pcls ? 3 : dany ? 2 : s_tr ? 1 : 0;
    wok  = rlen < s_mw;
    dok  = !dany || used < M;
    pass = s_req & wok & s_lock & !pcls;
    egate = pass & dok;
    chk("R1,R2,R3,R5,R7,R8", "gate_out", int'(gate_out), egate);
    chk("R1,R2,R7,R9", "status_class", int'(status_class), ecls);
    chk("R9", "status_sticky", int'(status_sticky), sticky);
    chk("R4,R8", "log_valid", int'(log_valid), lv);
    if (lv) begin
      chk("R4,R8", "log_time", int'(log_time), ltime);
      chk("R4,R8", "log_reason", int'(log_reason), lrsn);
      chk("R4", "log_temp", int'(log_temp), ltemp);
      chk("R4", "log_curr", int'(log_curr), lcurr);
      chk("R4", "log_refl", int'(log_refl), lrefl);
    end
    chk("R4", "prot_events", int'(prot_events), pe);
    chk("R6", "deg_episodes", int'(deg_episodes), ep);
    chk("R6", "deg_cycles", int'(deg_cycles), dcy);
    chk("R6", "deg_recoveries", int'(deg_recoveries), rc);
    chk("R5", "duty_drops", int'(duty_drops), drops);
    chk("R8", "width_faults", int'(width_faults), wf);
    // Next state as of the coming rising edge.
    pevt = pany & !pq;
    tevt = s_req & (rlen >= s_mw) & !tseen;
    if (pevt || tevt) begin
      ltime = t; ltemp = tp; lcurr = cu; lrefl = rf;
      lrsn = pevt ? (s_ot ? 1 : s_oc ? 2 : 3) : 4;
    end
    lv = pevt | tevt;
    pe += pevt; wf += tevt;
    ep += dany & !dq; dcy += dany; rc += !dany & dq;
    drops += pass & !dok;
    if (s_req) begin
      if (rlen < s_mw) rlen++;
      tseen = tseen | tevt;
    end else begin
      rlen = 0; tseen = 0;
    end
    if (t % WIN == WIN - 1) used = 0;
    else if (egate && used < M) used++;
    sticky = (s_clr ? 0 : sticky) | (pcls << 2) | (dany << 1) | s_tr;
    plat = pany | (plat & !s_clr);
    pq = pany; dq = dany;
    t++;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(int len, int gap);
    s_req = 1; run(len);
    s_req = 0; run(gap);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1..R9 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R9: everything zero in reset.
    chk("R9", "reset gate_out", int'(gate_out), 0);
    chk("R9", "reset status_class", int'(status_class), 0);
    chk("R9", "reset status_sticky", int'(status_sticky), 0);
    chk("R9", "reset log_valid", int'(log_valid), 0);
    chk("R9", "reset prot_events", int'(prot_events), 0);
    chk("R9", "reset width_faults", int'(width_faults), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: plain pulses with lock, then without lock.
    run(2);
    pulse(3, 2); pulse(1, 1);
    s_lock = 0; pulse(4, 2); s_lock = 1;

    // R8: sweep of width limit against run length.
    for (int mw = 0; mw <= 5; mw++) begin
      s_mw = mw;
      for (int len = 1; len <= 7; len++) pulse(len, 2);
    end
    s_mw = 8;

    // R1, R2, R4: each protect-flag combination with requests pending.
    for (int c = 1; c < 8; c++) begin
      s_req = 1; run(2);
      s_ot = c & 1; s_oc = (c >> 1) & 1; s_mm = (c >> 2) & 1;
      run(3);
      s_clr = 1; run(1); s_clr = 0;          // clear while active: no effect
      s_ot = 0; s_oc = 0; s_mm = 0; run(3);  // still latched
      s_clr = 1; run(1); s_clr = 0;          // effective clear
      run(3); s_req = 0; run(2);
    end
    // R4: staggered flags, second rise after a drop.
    s_req = 1; s_mm = 1; run(2); s_ot = 1; run(2); s_mm = 0; s_ot = 0; run(1);
    s_oc = 1; run(2); s_oc = 0; s_clr = 1; run(1); s_clr = 0; run(2); s_req = 0; run(2);

    // R5, R6: each degrade flag with continuous and sparse requests.
    s_mw = 255;
    for (int d = 0; d < 3; d++) begin
      s_wl = (d == 0); s_wt = (d == 1); s_wi = (d == 2);
      s_req = 1; run(40);
      s_req = 0; run(3);
      for (int k = 0; k < 10; k++) pulse(2, 1);
      s_wl = 0; s_wt = 0; s_wi = 0; run(5);
    end
    // R5: degrade entered mid-window after free gating.
    run((WIN - (t % WIN)) % WIN);
    s_req = 1; run(6); s_wt = 1; run(30); s_wt = 0; run(4); s_req = 0; run(3);
    s_mw = 8;

    // R7: trend flag alone and with requests.
    s_tr = 1; pulse(5, 3); pulse(2, 2); s_tr = 0; run(2);

    // R9: mixed classes, priority and sticky clearing.
    s_tr = 1; s_wi = 1; s_req = 1; run(4);
    s_ovt_on();
    run(3); s_ot = 0; s_clr = 1; run(1); s_clr = 0; run(3);
    s_wi = 0; run(2); s_tr = 0; run(2);
    s_clr = 1; run(1); s_clr = 0; run(3); s_req = 0; run(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic s_ovt_on();
    s_ot = 1;
  endtask
endmodule